// File: doc/BRIEF.md
# Supervisor/User Context Fuse Timer

This block decides which memory context a small processor system runs in: supervisor (kernel) or user (task). The `ctx_user` output drives external address translation. The translation tables themselves are outside this block.

An interrupt is seen as a vector fetch on a qualified processor cycle, and it forces the supervisor context at once. The return to the user context is armed ahead of time. Kernel code writes a cycle count into the fuse register and then issues its return-from-interrupt. The fuse counts qualified processor cycles down, and the context flips to user on the cycle the count runs out.

This timing is the point of the block. A count of 1 lands the switch just after the cycle that fetches the return opcode. Counts of 2 or 3 land it inside the two internal cycles (the second and third) of the seven-cycle return instruction. Only cycles with the clock enable high are counted, so stretched bus cycles do not shorten the countdown. A status output shows whether a countdown is pending.

Top module: `ctx_fuse_timer`

## Requirements
- R1: After reset, `ctx_user` is 0 (supervisor) and `fuse_busy` is 0 (no countdown).
- R2: A vector fetch (`vec_fetch`=1) on a qualified cycle (`clk_en`=1) makes `ctx_user` 0 from the next clock edge, whatever the previous mode.
- R3: In supervisor mode, a qualified write (`wr_en`=1) of a nonzero value N on `wr_data` loads the fuse. `fuse_busy` reads 1 from the next edge.
- R4: After a load of N, `ctx_user` becomes 1 and `fuse_busy` becomes 0 at the Nth qualified edge following the edge that captured the write. Before that edge, `ctx_user` stays 0.
- R5: Boundary counts behave as in R4. A load of 1 switches to user at the very next qualified edge. A load of 2^CNT_W-1 switches after exactly that many qualified edges.
- R6: A write of 0 does not start a countdown: `fuse_busy` stays 0 and the mode stays supervisor.
- R7: Writes made while `ctx_user`=1 are ignored. The mode stays user and `fuse_busy` stays 0.
- R8: A vector fetch during a countdown cancels it: `fuse_busy` goes to 0 and the mode stays supervisor.
- R9: On cycles with `clk_en`=0, nothing changes: no decrement, and vector fetches and writes have no effect.
- R10: A vector fetch and a write on the same qualified cycle act as a vector fetch alone. No countdown starts.
- R11: A nonzero write during a countdown reloads the counter with the new value. R4 timing then restarts from that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low reset (synchronous to clk) |
| clk_en | input | 1 | Qualifies a processor cycle; low during stretched bus cycles |
| vec_fetch | input | 1 | Processor is fetching an interrupt vector |
| wr_en | input | 1 | Write strobe for the fuse register |
| wr_data | input | CNT_W | Cycle count to load into the fuse |
| ctx_user | output | 1 | 1 = user context, 0 = supervisor context |
| fuse_busy | output | 1 | Status: a countdown is in progress |

## Verification
The assertions assume that `clk_en`, `vec_fetch`, `wr_en` and `wr_data` are valid at every rising edge. They also assume that a vector fetch and a write may coincide, and that nothing else constrains when writes arrive. The bench changes all inputs only on falling clock edges, so every rising edge sees settled values. It deliberately produces the awkward combinations: writes in user mode, zero writes, vector fetches during a countdown or alongside a write, and long runs with `clk_en` held low while other inputs toggle.

// File: rtl/ctx_fuse_pkg.sv
package ctx_fuse_pkg;
    typedef enum logic {
        CTX_SUPER = 1'b0,
        CTX_USER  = 1'b1
    } ctx_mode_e;
endpackage

// File: rtl/ctx_fuse_counter.sv
module ctx_fuse_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cancel,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             busy,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       expire_d;

    always_comb begin
        st_d     = st_q;
        expire_d = 1'b0;
        if (tick) begin
            if (cancel) begin
                st_d.cnt = '0;
            end else if (load) begin
                st_d.cnt = load_val;
            end else if (st_q.cnt != '0) begin
                st_d.cnt = st_q.cnt - ONE;
                expire_d = (st_q.cnt == ONE);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy   = (st_q.cnt != '0);
    assign expire = expire_d;

    // A running count with no other event steps down by exactly one (R4)
    assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cancel && !load && busy) |=> (st_q.cnt == $past(st_q.cnt) - ONE));

    // Without a tick the count holds (R9)
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(st_q.cnt));
endmodule

// File: rtl/ctx_mode_ctrl.sv
module ctx_mode_ctrl
    import ctx_fuse_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic vec,
    input  logic expire,
    output logic user
);
    typedef struct packed {
        ctx_mode_e mode;
    } mode_state_t;

    mode_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick) begin
            if (vec)         st_d.mode = CTX_SUPER;
            else if (expire) st_d.mode = CTX_USER;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{mode: CTX_SUPER};
        else        st_q <= st_d;
    end

    assign user = (st_q.mode == CTX_USER);

    // Entering user mode needs an expiry on a qualified cycle (R4)
    assert_enter_user_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(user) |-> ($past(expire) && $past(tick)));
endmodule

// File: rtl/ctx_fuse_timer.sv
module ctx_fuse_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             vec_fetch,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic             ctx_user,
    output logic             fuse_busy
);
    logic load_ok;
    logic expire;
    logic user_q;
    logic busy_q;

    assign load_ok = wr_en && !user_q && (wr_data != '0);

    ctx_fuse_counter #(.CNT_W(CNT_W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (clk_en),
        .cancel   (vec_fetch),
        .load     (load_ok),
        .load_val (wr_data),
        .busy     (busy_q),
        .expire   (expire)
    );

    ctx_mode_ctrl u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (clk_en),
        .vec    (vec_fetch),
        .expire (expire),
        .user   (user_q)
    );

    assign ctx_user  = user_q;
    assign fuse_busy = busy_q;

    assert_vec_super_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && vec_fetch) |=> !ctx_user);

    assert_vec_cancel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && vec_fetch) |=> !fuse_busy);

    assert_zero_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !fuse_busy && wr_en && wr_data == '0) |=> !fuse_busy);

    assert_user_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_user && !(clk_en && vec_fetch)) |=> (ctx_user && !fuse_busy));

    assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> ($stable(ctx_user) && $stable(fuse_busy)));

    assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !vec_fetch && !ctx_user && wr_en && wr_data != '0) |=> fuse_busy);
endmodule

// File: tb/ctx_fuse_timer_tb.sv
`timescale 1ns/1ps
module ctx_fuse_timer_tb;
    localparam int CNT_W = 8;
    localparam int NROWS = 22;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clk_en = 1'b0;
    logic vec_fetch = 1'b0;
    logic wr_en = 1'b0;
    logic [CNT_W-1:0] wr_data = '0;
    logic ctx_user;
    logic fuse_busy;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ctx_fuse_timer #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .vec_fetch(vec_fetch),
        .wr_en(wr_en), .wr_data(wr_data), .ctx_user(ctx_user), .fuse_busy(fuse_busy)
    );

    // row = {en, vec, wr, data[7:0], exp_user, exp_busy, req[3:0]}
    localparam logic [16:0] TBL [NROWS] = '{
        {3'b101, 8'd3, 2'b01, 4'd3},   // R3 load 3
        {3'b100, 8'd0, 2'b01, 4'd4},   // R4 count 2 left
        {3'b000, 8'd0, 2'b01, 4'd9},   // R9 stall, no decrement
        {3'b100, 8'd0, 2'b01, 4'd4},   // R4 count 1 left
        {3'b100, 8'd0, 2'b10, 4'd4},   // R4 expire -> user
        {3'b101, 8'd5, 2'b10, 4'd7},   // R7 write in user ignored
        {3'b100, 8'd0, 2'b10, 4'd7},   // R7 still user, idle
        {3'b110, 8'd0, 2'b00, 4'd2},   // R2 vector fetch -> supervisor
        {3'b101, 8'd0, 2'b00, 4'd6},   // R6 zero write ignored
        {3'b101, 8'd4, 2'b01, 4'd3},   // R3 load 4
        {3'b110, 8'd0, 2'b00, 4'd8},   // R8 vector cancels countdown
        {3'b100, 8'd0, 2'b00, 4'd8},   // R8 stays supervisor
        {3'b101, 8'd1, 2'b01, 4'd5},   // R5 load 1
        {3'b100, 8'd0, 2'b10, 4'd5},   // R5 switch after one edge
        {3'b111, 8'd2, 2'b00, 4'd2},   // R2 vector from user with write
        {3'b111, 8'd2, 2'b00, 4'd10},  // R10 vector beats write in supervisor
        {3'b101, 8'd6, 2'b01, 4'd3},   // R3 load 6
        {3'b100, 8'd0, 2'b01, 4'd11},  // R11 count 5
        {3'b101, 8'd2, 2'b01, 4'd11},  // R11 reload 2
        {3'b100, 8'd0, 2'b01, 4'd11},  // R11 count 1
        {3'b011, 8'd9, 2'b01, 4'd9},   // R9 vec+write with clk_en low ignored
        {3'b100, 8'd0, 2'b10, 4'd11}   // R11 expire on reloaded count
    };

    task automatic check(input string req, input logic au, input logic ab,
                         input logic eu, input logic eb);
        checks++;
        if (au !== eu || ab !== eb) begin
            errors++;
            $display("FAIL %s: actual user=%b busy=%b expected user=%b busy=%b",
                     req, au, ab, eu, eb);
        end
    endtask

    task automatic step(input logic en, input logic v, input logic w,
                        input logic [CNT_W-1:0] d);
        @(negedge clk);
        clk_en = en; vec_fetch = v; wr_en = w; wr_data = d;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1", ctx_user, fuse_busy, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1", ctx_user, fuse_busy, 1'b0, 1'b0);

        for (int i = 0; i < NROWS; i++) begin
            step(TBL[i][16], TBL[i][15], TBL[i][14], TBL[i][13:6]);
            check($sformatf("R%0d row %0d", TBL[i][3:0], i),
                  ctx_user, fuse_busy, TBL[i][5], TBL[i][4]);
        end

        // R5 maximum count: switch after exactly 255 qualified edges
        step(1'b1, 1'b1, 1'b0, 8'd0);
        step(1'b1, 1'b0, 1'b1, 8'd255);
        for (int k = 1; k < 255; k++) begin
            step(1'b1, 1'b0, 1'b0, 8'd0);
            if (k == 128) step(1'b0, 1'b0, 1'b0, 8'd0);
        end
        check("R5 max count edge 254", ctx_user, fuse_busy, 1'b0, 1'b1);
        step(1'b1, 1'b0, 1'b0, 8'd0);
        check("R5 max count edge 255", ctx_user, fuse_busy, 1'b1, 1'b0);

        // R1 reset in the middle of a countdown
        step(1'b1, 1'b1, 1'b0, 8'd0);
        step(1'b1, 1'b0, 1'b1, 8'd7);
        check("R3 load before reset", ctx_user, fuse_busy, 1'b0, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        clk_en = 1'b0; wr_en = 1'b0;
        @(posedge clk);
        #1;
        check("R1 reset mid countdown", ctx_user, fuse_busy, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (10) step(1'b1, 1'b0, 1'b0, 8'd0);
        check("R1 no countdown after reset", ctx_user, fuse_busy, 1'b0, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule